// File: doc/BRIEF.md
# Controller Command Dispatcher

This block sits behind the byte-level transfer engine of a system-management controller. The engine hands it each host packet as a stream of bytes, the final one flagged. The first byte selects the packet class. A serial peripheral bus packet is passed on to an external port with its class byte removed. A controller command packet is decoded and executed. Packets of any other class are discarded without a reply.

The supported commands cover three areas: the autopoll settings (enable, rate and device mask), one-cycle requests for power-down and system reset, and a seconds-resolution clock that can be read and set. Every command gets a reply packet, sent back one byte per cycle with the final byte flagged. A good command is answered with a header that echoes its command byte. A command with the wrong argument count or an illegal argument gets a bad-parameter error reply, and a command code the block does not know gets an unknown-command error reply. The clock is held as a 32-bit offset added to a free-running counter of elapsed seconds. Its reset value counts seconds from the start of 1904.

Top module: `cmdp_dispatch`

## Requirements
- R1: After reset there is no reply in progress. Autopoll is disabled, the rate equals RATE_INIT (11), the mask equals MASK_INIT (0), both request outputs are low, and the clock reads UNIX_INIT + 2082844800 plus the seconds counted since reset.
- R2: A good command is answered with the bytes 0x01, 0x00, the command byte, and then any result bytes. The first byte appears in the second cycle after the packet's last byte. The bytes follow on consecutive cycles, and the final one carries out_last.
- R3: A command code outside the set below is answered with 0x02, 0x02, 0x01, and then the command byte.
- R4: A known command with the wrong argument count is answered with 0x02, 0x05, 0x01, and then the command byte, and it changes no state.
- R5: Command 0x01 takes one argument. A nonzero argument enables autopoll and zero disables it.
- R6: Command 0x14 takes one argument and sets the autopoll rate to it. An argument of zero is rejected with the bad-parameter reply, and the rate keeps its value.
- R7: Command 0x19 takes two arguments and sets the 16-bit mask, with the first argument as the high byte.
- R8: Commands 0x0A (power-down) and 0x11 (system reset) take no arguments. Each drives its request output high for exactly one cycle, and that cycle is the one in which the reply's first byte appears. A rejected command raises no request.
- R9: Command 0x03 takes no arguments and returns four bytes, most significant first, equal to offset plus elapsed seconds. The value is sampled in the cycle after the last packet byte, so a tick in that same cycle is not included.
- R10: Command 0x09 takes four bytes, most significant first. Afterwards the clock reads that value plus the number of ticks from the decision cycle onward.
- R11: For a packet whose class byte is 0x00, each later byte appears on fwd_data one cycle after it is accepted, with fwd_last marking the final byte, and no reply is sent. Packets of class 0x02 to 0x05, and controller packets that carry no command byte, get no reply and change no state.
- R12: Input bytes that arrive while a reply is pending or being sent are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host packet byte present |
| in_data | input | 8 | Host packet byte |
| in_last | input | 1 | Final byte of host packet |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| out_valid | output | 1 | Reply byte present |
| out_data | output | 8 | Reply byte |
| out_last | output | 1 | Final reply byte |
| fwd_valid | output | 1 | Forwarded peripheral-bus byte present |
| fwd_data | output | 8 | Forwarded peripheral-bus byte |
| fwd_last | output | 1 | Final forwarded byte |
| autopoll_en | output | 1 | Autopoll enable |
| autopoll_rate | output | 8 | Autopoll rate |
| autopoll_mask | output | 16 | Autopoll device mask |
| pwr_down_req | output | 1 | Power-down request pulse |
| sys_reset_req | output | 1 | System reset request pulse |

## Verification
A second tick and a clock read or write can land in the same cycle. This happens when sec_tick is high in the cycle that a get-time or set-time command is decided. The bench provokes the collision by raising the tick in the cycle right after the last packet byte. For a read it expects the value from before the tick. For a write it expects a later read to show the written value plus that tick. A second collision is a new packet arriving while a reply is being sent. The bench judges this one by the absence of any extra reply and by the autopoll output staying unchanged.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;
  localparam logic [7:0] PT_BUS    = 8'h00;
  localparam logic [7:0] PT_CTRL   = 8'h01;
  localparam logic [7:0] PT_ERR    = 8'h02;
  localparam logic [7:0] PT_TIMER  = 8'h03;
  localparam logic [7:0] PT_POWER  = 8'h04;
  localparam logic [7:0] PT_IIC    = 8'h05;

  localparam logic [7:0] C_POLL_EN = 8'h01;
  localparam logic [7:0] C_TIME_RD = 8'h03;
  localparam logic [7:0] C_TIME_WR = 8'h09;
  localparam logic [7:0] C_PWR_OFF = 8'h0A;
  localparam logic [7:0] C_SYS_RST = 8'h11;
  localparam logic [7:0] C_RATE    = 8'h14;
  localparam logic [7:0] C_DEVMASK = 8'h19;

  localparam logic [7:0] E_UNKNOWN = 8'h02;
  localparam logic [7:0] E_BADARG  = 8'h05;

  localparam logic [31:0] EPOCH_SHIFT = 32'd2082844800;

  function automatic logic [31:0] clk_read(input logic [31:0] ofs, input logic [31:0] secs);
    return ofs + secs;
  endfunction

  function automatic logic [31:0] clk_rebase(input logic [31:0] val, input logic [31:0] secs);
    return val - secs;
  endfunction

  function automatic logic [31:0] be_word(input logic [7:0] b0, input logic [7:0] b1,
                                          input logic [7:0] b2, input logic [7:0] b3);
    return {b0, b1, b2, b3};
  endfunction
endpackage

// File: rtl/cmdp_collect.sv
module cmdp_collect
  import cmdp_pkg::*;
#(
  parameter int MAXA = 4,
  parameter int CW   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [7:0]            in_data,
  input  logic                  in_last,
  input  logic                  hold,
  output logic                  pkt_done,
  output logic [7:0]            pkt_type,
  output logic [7:0]            pkt_cmd,
  output logic [MAXA-1:0][7:0]  pkt_args,
  output logic [CW-1:0]         pkt_len,
  output logic                  fwd_valid,
  output logic [7:0]            fwd_data,
  output logic                  fwd_last
);
  logic take;
  logic first_q;

  assign take = in_valid && !hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q   <= 1'b1;
      pkt_done  <= 1'b0;
      pkt_type  <= '0;
      pkt_cmd   <= '0;
      pkt_args  <= '0;
      pkt_len   <= '0;
      fwd_valid <= 1'b0;
      fwd_data  <= '0;
      fwd_last  <= 1'b0;
    end else begin
      pkt_done  <= take && in_last;
      fwd_valid <= take && !first_q && (pkt_type == PT_BUS);
      fwd_data  <= in_data;
      fwd_last  <= in_last;
      if (take) begin
        first_q <= in_last;
        if (first_q) begin
          pkt_type <= in_data;
          pkt_len  <= CW'(1);
        end else begin
          if (pkt_len == CW'(1)) pkt_cmd <= in_data;
          for (int i = 0; i < MAXA; i++)
            if (pkt_len == CW'(i + 2)) pkt_args[i] <= in_data;
          if (pkt_len != '1) pkt_len <= pkt_len + CW'(1);
        end
      end
    end
  end

  p_drop_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && in_valid) |=> !pkt_done);
endmodule

// File: rtl/cmdp_rtc.sv
module cmdp_rtc
  import cmdp_pkg::*;
#(
  parameter logic [31:0] INIT = EPOCH_SHIFT
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        set_en,
  input  logic [31:0] set_val,
  output logic [31:0] now
);
  logic [31:0] secs_q;
  logic [31:0] ofs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      secs_q <= '0;
      ofs_q  <= INIT;
    end else begin
      secs_q <= secs_q + {31'b0, tick};
      if (set_en) ofs_q <= clk_rebase(set_val, secs_q);
    end
  end

  assign now = clk_read(ofs_q, secs_q);

  p_tick_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !set_en) |=> now == $past(now) + 32'd1);
  p_set_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> now == $past(set_val) + {31'b0, $past(tick)});
endmodule

// File: rtl/cmdp_emit.sv
module cmdp_emit #(
  parameter int MAXR = 7,
  localparam int LW  = $clog2(MAXR + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [LW-1:0]        load_len,
  input  logic [MAXR-1:0][7:0] load_bytes,
  output logic                 out_valid,
  output logic [7:0]           out_data,
  output logic                 out_last
);
  logic [MAXR-1:0][7:0] buf_q;
  logic [LW-1:0]        len_q;
  logic [LW-1:0]        idx_q;
  logic                 act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= '0;
      len_q <= '0;
      idx_q <= '0;
      act_q <= 1'b0;
    end else if (load) begin
      buf_q <= load_bytes;
      len_q <= load_len;
      idx_q <= '0;
      act_q <= 1'b1;
    end else if (act_q) begin
      if (out_last) act_q <= 1'b0;
      else          idx_q <= idx_q + LW'(1);
    end
  end

  assign out_valid = act_q;
  assign out_data  = buf_q[idx_q];
  assign out_last  = act_q && (idx_q == len_q - LW'(1));

  p_contiguous_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid);
  p_no_overlap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !out_valid);
endmodule

// File: rtl/cmdp_dispatch.sv
module cmdp_dispatch
  import cmdp_pkg::*;
#(
  parameter logic [31:0] UNIX_INIT = 32'd0,
  parameter logic [7:0]  RATE_INIT = 8'd11,
  parameter logic [15:0] MASK_INIT = 16'h0000,
  parameter int          MAXA      = 4,
  parameter int          MAXR      = 7,
  parameter int          CW        = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic        sec_tick,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_last,
  output logic        fwd_valid,
  output logic [7:0]  fwd_data,
  output logic        fwd_last,
  output logic        autopoll_en,
  output logic [7:0]  autopoll_rate,
  output logic [15:0] autopoll_mask,
  output logic        pwr_down_req,
  output logic        sys_reset_req
);
  localparam int LW = $clog2(MAXR + 1);
  localparam logic [31:0] CLK_INIT = UNIX_INIT + EPOCH_SHIFT;

  logic                 pkt_done;
  logic [7:0]           pkt_type, pkt_cmd;
  logic [MAXA-1:0][7:0] pkt_args;
  logic [CW-1:0]        pkt_len, nargs;
  logic                 is_cmd, known, arg_ok, do_ok;
  logic [LW-1:0]        r_len;
  logic [MAXR-1:0][7:0] r_bytes;
  logic [31:0]          now;
  logic                 time_set;

  cmdp_collect #(.MAXA(MAXA), .CW(CW)) u_collect (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .hold(out_valid || pkt_done), .pkt_done(pkt_done),
    .pkt_type(pkt_type), .pkt_cmd(pkt_cmd), .pkt_args(pkt_args),
    .pkt_len(pkt_len), .fwd_valid(fwd_valid), .fwd_data(fwd_data),
    .fwd_last(fwd_last));

  assign nargs  = pkt_len - CW'(2);
  assign is_cmd = pkt_done && (pkt_type == PT_CTRL) && (pkt_len >= CW'(2));

  always_comb begin
    known  = 1'b1;
    arg_ok = 1'b0;
    unique case (pkt_cmd)
      C_POLL_EN:                     arg_ok = (nargs == CW'(1));
      C_RATE:                        arg_ok = (nargs == CW'(1)) && (pkt_args[0] != 8'h00);
      C_DEVMASK:                     arg_ok = (nargs == CW'(2));
      C_PWR_OFF, C_SYS_RST, C_TIME_RD: arg_ok = (nargs == CW'(0));
      C_TIME_WR:                     arg_ok = (nargs == CW'(4));
      default:                       known  = 1'b0;
    endcase
  end

  assign do_ok    = is_cmd && known && arg_ok;
  assign time_set = do_ok && (pkt_cmd == C_TIME_WR);

  always_comb begin
    r_bytes = '0;
    r_len   = LW'(4);
    if (!known || !arg_ok) begin
      r_bytes[0] = PT_ERR;
      r_bytes[1] = known ? E_BADARG : E_UNKNOWN;
      r_bytes[2] = PT_CTRL;
      r_bytes[3] = pkt_cmd;
    end else begin
      r_bytes[0] = PT_CTRL;
      r_bytes[1] = 8'h00;
      r_bytes[2] = pkt_cmd;
      r_len      = LW'(3);
      if (pkt_cmd == C_TIME_RD) begin
        r_bytes[3] = now[31:24];
        r_bytes[4] = now[23:16];
        r_bytes[5] = now[15:8];
        r_bytes[6] = now[7:0];
        r_len      = LW'(7);
      end
    end
  end

  cmdp_rtc #(.INIT(CLK_INIT)) u_rtc (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick), .set_en(time_set),
    .set_val(be_word(pkt_args[0], pkt_args[1], pkt_args[2], pkt_args[3])),
    .now(now));

  cmdp_emit #(.MAXR(MAXR)) u_emit (
    .clk(clk), .rst_n(rst_n), .load(is_cmd), .load_len(r_len),
    .load_bytes(r_bytes), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      autopoll_en   <= 1'b0;
      autopoll_rate <= RATE_INIT;
      autopoll_mask <= MASK_INIT;
      pwr_down_req  <= 1'b0;
      sys_reset_req <= 1'b0;
    end else begin
      pwr_down_req  <= do_ok && (pkt_cmd == C_PWR_OFF);
      sys_reset_req <= do_ok && (pkt_cmd == C_SYS_RST);
      if (do_ok && pkt_cmd == C_POLL_EN) autopoll_en   <= (pkt_args[0] != 8'h00);
      if (do_ok && pkt_cmd == C_RATE)    autopoll_rate <= pkt_args[0];
      if (do_ok && pkt_cmd == C_DEVMASK) autopoll_mask <= {pkt_args[0], pkt_args[1]};
    end
  end

  p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down_req || sys_reset_req) |=> !(pwr_down_req || sys_reset_req));
  p_req_with_reply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down_req || sys_reset_req) |-> $rose(out_valid));
  p_poll_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(autopoll_en) |-> $rose(out_valid));
  p_reply_header_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_data == PT_CTRL || out_data == PT_ERR));
endmodule

// File: tb/cmdp_dispatch_test.sv
module cmdp_dispatch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_last = 1'b0, sec_tick = 1'b0;
  logic [7:0]  in_data = '0;
  logic        out_valid, out_last, fwd_valid, fwd_last;
  logic [7:0]  out_data, fwd_data, autopoll_rate;
  logic        autopoll_en, pwr_down_req, sys_reset_req;
  logic [15:0] autopoll_mask;

  int checks = 0, errs = 0;
  bit done = 1'b0;
  string cur_req = "R1";
  logic [8:0] rq[$];
  logic [8:0] fq[$];
  logic [7:0] pk [8];
  logic [31:0] elap_m = 0, ofs_m = 32'd2082844800;

  always #4 clk = ~clk;

  cmdp_dispatch uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .sec_tick(sec_tick), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .fwd_valid(fwd_valid),
    .fwd_data(fwd_data), .fwd_last(fwd_last), .autopoll_en(autopoll_en),
    .autopoll_rate(autopoll_rate), .autopoll_mask(autopoll_mask),
    .pwr_down_req(pwr_down_req), .sys_reset_req(sys_reset_req));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rq.size() == 0) chk(1'b0, {cur_req, " unexpected reply"}, {23'b0, out_last, out_data}, 32'h0);
      else begin
        automatic logic [8:0] e = rq.pop_front();
        chk({out_last, out_data} == e, cur_req, {23'b0, out_last, out_data}, {23'b0, e});
      end
    end
    if (rst_n && fwd_valid) begin
      if (fq.size() == 0) chk(1'b0, "R11 unexpected forward", {23'b0, fwd_last, fwd_data}, 32'h0);
      else begin
        automatic logic [8:0] e = fq.pop_front();
        chk({fwd_last, fwd_data} == e, "R11", {23'b0, fwd_last, fwd_data}, {23'b0, e});
      end
    end
  end

  task automatic exp_ok(input logic [7:0] cmd, input bit with_time, input logic [31:0] t);
    rq.push_back({1'b0, 8'h01});
    rq.push_back({1'b0, 8'h00});
    rq.push_back({!with_time, cmd});
    if (with_time) begin
      rq.push_back({1'b0, t[31:24]});
      rq.push_back({1'b0, t[23:16]});
      rq.push_back({1'b0, t[15:8]});
      rq.push_back({1'b1, t[7:0]});
    end
  endtask

  task automatic exp_err(input logic [7:0] code, input logic [7:0] cmd);
    rq.push_back({1'b0, 8'h02});
    rq.push_back({1'b0, code});
    rq.push_back({1'b0, 8'h01});
    rq.push_back({1'b1, cmd});
  endtask

  // returns at the negedge of the cycle in which a reply's first byte is visible
  task automatic send(input int n, input bit tick_done);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = pk[i]; in_last = (i == n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; sec_tick = tick_done;
    @(negedge clk);
    if (sec_tick) elap_m++;
    sec_tick = 1'b0;
  endtask

  task automatic settle();
    while (out_valid) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(rq.size() == 0, {cur_req, " reply length"}, rq.size(), 0);
  endtask

  task automatic ticks(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0; elap_m++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!out_valid, "R1", out_valid, 0);
    chk(!autopoll_en, "R1", autopoll_en, 0);
    chk(autopoll_rate == 8'd11, "R1", autopoll_rate, 11);
    chk(autopoll_mask == 16'h0, "R1", autopoll_mask, 0);
    chk(!pwr_down_req && !sys_reset_req, "R1", {pwr_down_req, sys_reset_req}, 0);

    // R9 / R1: clock after reset
    cur_req = "R9"; pk[0] = 8'h01; pk[1] = 8'h03;
    exp_ok(8'h03, 1'b1, ofs_m + elap_m); send(2, 1'b0); settle();

    // R9: tick in decision cycle excluded
    ticks(3);
    exp_ok(8'h03, 1'b1, ofs_m + elap_m); send(2, 1'b1); settle();

    // R10: set time with coincident tick
    cur_req = "R10";
    pk[0] = 8'h01; pk[1] = 8'h09; pk[2] = 8'h12; pk[3] = 8'h34; pk[4] = 8'h56; pk[5] = 8'h78;
    exp_ok(8'h09, 1'b0, 0); ofs_m = 32'h12345678 - elap_m; send(6, 1'b1); settle();
    pk[1] = 8'h03;
    exp_ok(8'h03, 1'b1, 32'h12345679); send(2, 1'b0); settle();
    ticks(2);
    exp_ok(8'h03, 1'b1, 32'h1234567B); send(2, 1'b0); settle();

    // R5 autopoll enable / disable
    cur_req = "R5"; pk[1] = 8'h01; pk[2] = 8'h05;
    exp_ok(8'h01, 1'b0, 0); send(3, 1'b0); settle();
    chk(autopoll_en, "R5", autopoll_en, 1);
    pk[2] = 8'h00;
    exp_ok(8'h01, 1'b0, 0); send(3, 1'b0); settle();
    chk(!autopoll_en, "R5", autopoll_en, 0);

    // R4 wrong length leaves state
    cur_req = "R4"; pk[2] = 8'h07; pk[3] = 8'h07;
    exp_err(8'h05, 8'h01); send(4, 1'b0); settle();
    chk(!autopoll_en, "R4", autopoll_en, 0);

    // R6 rate
    cur_req = "R6"; pk[1] = 8'h14; pk[2] = 8'h20;
    exp_ok(8'h14, 1'b0, 0); send(3, 1'b0); settle();
    chk(autopoll_rate == 8'h20, "R6", autopoll_rate, 32'h20);
    pk[2] = 8'h00;
    exp_err(8'h05, 8'h14); send(3, 1'b0); settle();
    chk(autopoll_rate == 8'h20, "R6", autopoll_rate, 32'h20);

    // R7 mask
    cur_req = "R7"; pk[1] = 8'h19; pk[2] = 8'hA5; pk[3] = 8'h3C;
    exp_ok(8'h19, 1'b0, 0); send(4, 1'b0); settle();
    chk(autopoll_mask == 16'hA53C, "R7", autopoll_mask, 32'hA53C);
    cur_req = "R4";
    exp_err(8'h05, 8'h19); send(3, 1'b0); settle();
    chk(autopoll_mask == 16'hA53C, "R4", autopoll_mask, 32'hA53C);

    // R8 requests
    cur_req = "R8"; pk[1] = 8'h0A;
    exp_ok(8'h0A, 1'b0, 0); send(2, 1'b0);
    chk(pwr_down_req && !sys_reset_req, "R8", {pwr_down_req, sys_reset_req}, 2);
    @(negedge clk);
    chk(!pwr_down_req, "R8", pwr_down_req, 0);
    settle();
    pk[1] = 8'h11;
    exp_ok(8'h11, 1'b0, 0); send(2, 1'b0);
    chk(sys_reset_req && !pwr_down_req, "R8", {pwr_down_req, sys_reset_req}, 1);
    @(negedge clk);
    chk(!sys_reset_req, "R8", sys_reset_req, 0);
    settle();
    pk[1] = 8'h0A; pk[2] = 8'h01;
    exp_err(8'h05, 8'h0A); send(3, 1'b0);
    chk(!pwr_down_req, "R8", pwr_down_req, 0);
    settle();

    // R3 unknown
    cur_req = "R3"; pk[1] = 8'h55;
    exp_err(8'h02, 8'h55); send(3, 1'b0); settle();
    cur_req = "R4"; pk[1] = 8'h03; pk[2] = 8'h00;
    exp_err(8'h05, 8'h03); send(3, 1'b0); settle();

    // R11 forwarding and silent classes
    cur_req = "R11"; pk[0] = 8'h00; pk[1] = 8'hAB; pk[2] = 8'hCD;
    fq.push_back({1'b0, 8'hAB}); fq.push_back({1'b1, 8'hCD});
    send(3, 1'b0); settle();
    chk(fq.size() == 0, "R11 forward count", fq.size(), 0);
    pk[0] = 8'h04; pk[1] = 8'h01; pk[2] = 8'h01;
    send(3, 1'b0); settle();
    chk(!autopoll_en, "R11", autopoll_en, 0);
    pk[0] = 8'h01;
    send(1, 1'b0); settle();

    // R12 bytes during a reply are dropped
    cur_req = "R12"; pk[0] = 8'h01; pk[1] = 8'h03;
    exp_ok(8'h03, 1'b1, ofs_m + elap_m); send(2, 1'b0);
    pk[1] = 8'h01; pk[2] = 8'h09;
    for (int i = 0; i < 3; i++) begin
      in_valid = 1'b1; in_data = pk[i]; in_last = (i == 2);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    settle();
    chk(!autopoll_en, "R12", autopoll_en, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule